// File: doc/BRIEF.md
# Reference Clock Output Generator

This block produces a divided reference clock for an output pin. A 16-bit control word, written through a plain write port and readable on a parallel output, turns the output on, chooses which of two clock sources feeds it, sets a power-of-two division and decides whether the output survives low-power sleep. The two sources are a primary oscillator and the live system clock. When the system clock is chosen, the output follows whatever rate that clock has at the time, including after a clock switch.

The block runs in a single fabric clock `clk`. Each source is presented as an edge strobe: a one-cycle pulse on `pri_tick` or `sys_tick` marks one edge (one half period) of that source clock. The divider counts strobes of the active source and toggles `ref_out` after every 2^n of them. So code 0 passes the source through unchanged, and code n divides its frequency by 2^n.

A new division code or source choice is taken up only at the start of a low half of the output. Because of this, no shortened high or low phase ever reaches the pin. Clearing the enable drives the output low and clears the count.

Top module: `refclk_gen`

## Requirements
- R1: After reset, `ref_out` is 0 and `cfg_rdata` is 16'h0000.
- R2: A write with `cfg_we` high stores `cfg_wdata` in full, and the stored word appears on `cfg_rdata` from the next clock on.
- R3: While bit 15 (enable) of the stored word is 0, `ref_out` is 0 one cycle later and the strobe count is cleared. After enable is set again, the output starts low and first rises after a full half period.
- R4: Bits 11:8 hold a division code n from 0 to 15. `ref_out` toggles on every 2^n-th strobe of the active source, so code 0 toggles it on every strobe.
- R5: Bit 12 chooses the source: 1 counts `pri_tick` and 0 counts `sys_tick`. Strobes on the other input leave `ref_out` and the count unchanged.
- R6: A new code or source choice becomes active only at the start of a low half. A high half that is in progress completes with the old settings, and the active settings never change while `ref_out` is 1.
- R7: While `sleep` is 1, strobes are ignored and `ref_out` holds its level, unless bit 13 (keep-in-sleep), bit 12 and `pri_mode` are all 1.
- R8: When bit 13, bit 12 and `pri_mode` are all 1, division continues unchanged during `sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word to store |
| cfg_rdata | output | 16 | Stored control word |
| pri_tick | input | 1 | Edge strobe of the primary oscillator |
| sys_tick | input | 1 | Edge strobe of the system clock |
| pri_mode | input | 1 | Primary oscillator runs in a primary mode |
| sleep | input | 1 | Device is in low-power sleep |
| ref_out | output | 1 | Reference clock output (registered) |

## Verification
A write becomes visible on `cfg_rdata` one clock after the write edge. A strobe moves `ref_out` at the same edge that samples it. Disabling clears the output one edge after the stored enable bit drops. The bench drives every input at a falling edge and samples at the next falling edge, after exactly one rising edge has passed. Each strobe is followed by an idle cycle, so every setting change has a clean edge on which the divider takes it up, and the expected level after k strobes is computed as the parity of k divided by the half period.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int REG_W    = 16;
  localparam int DIV_W    = 4;
  localparam int EN_BIT   = 15;
  localparam int KEEP_BIT = 13;
  localparam int SEL_BIT  = 12;
  localparam int DIV_LSB  = 8;
  localparam int CNT_W    = (1 << DIV_W) - 1;

  typedef struct packed {
    logic             sel;
    logic [DIV_W-1:0] div;
  } setting_t;
endpackage

// File: rtl/refclk_ctrl_reg.sv
module refclk_ctrl_reg
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/refclk_src_gate.sv
module refclk_src_gate (
  input  logic pri_tick,
  input  logic sys_tick,
  input  logic act_sel,
  input  logic keep_bit,
  input  logic sel_bit,
  input  logic pri_mode,
  input  logic sleep,
  output logic tick
);
  logic keep_ok;
  logic raw;
  always_comb begin
    keep_ok = keep_bit && sel_bit && pri_mode;
    raw     = act_sel ? pri_tick : sys_tick;
    tick    = raw && !(sleep && !keep_ok);
  end
endmodule

// File: rtl/refclk_div.sv
module refclk_div
  import refclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     tick,
  input  setting_t cfg_set,
  output setting_t act_eff,
  output logic     out_q
);
  setting_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             low_start;

  always_comb begin
    low_start = !out_q && (cnt_q == '0);
    act_eff   = low_start ? cfg_set : act_q;
    term      = (CNT_W'(1) << act_eff.div) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_eff;
      if (!run) begin
        cnt_q <= '0;
        out_q <= 1'b0;
      end else if (tick) begin
        if (cnt_q == term) begin
          cnt_q <= '0;
          out_q <= ~out_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        pri_tick,
  input  logic        sys_tick,
  input  logic        pri_mode,
  input  logic        sleep,
  output logic        ref_out
);
  logic [REG_W-1:0] ctrl_q;
  setting_t         cfg_set;
  setting_t         act_eff;
  logic             tick_g;

  refclk_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(ctrl_q)
  );

  always_comb begin
    cfg_set.sel = ctrl_q[SEL_BIT];
    cfg_set.div = ctrl_q[DIV_LSB +: DIV_W];
  end

  refclk_src_gate u_gate (
    .pri_tick(pri_tick), .sys_tick(sys_tick), .act_sel(act_eff.sel),
    .keep_bit(ctrl_q[KEEP_BIT]), .sel_bit(ctrl_q[SEL_BIT]),
    .pri_mode(pri_mode), .sleep(sleep), .tick(tick_g)
  );

  refclk_div u_div (
    .clk(clk), .rst(rst), .run(ctrl_q[EN_BIT]), .tick(tick_g),
    .cfg_set(cfg_set), .act_eff(act_eff), .out_q(ref_out)
  );

  assign cfg_rdata = ctrl_q;
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk
  import refclk_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [15:0] cfg_rdata,
  input logic        pri_tick,
  input logic        sys_tick,
  input logic        pri_mode,
  input logic        sleep,
  input logic        ref_out,
  input setting_t    act_eff,
  input logic        tick_g
);
  logic blocked;
  assign blocked = sleep && !(cfg_rdata[KEEP_BIT] && cfg_rdata[SEL_BIT] && pri_mode);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!ref_out && cfg_rdata == 16'h0000));

  assert_disable_low_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[EN_BIT] |=> !ref_out);

  assert_code0_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[EN_BIT] && tick_g && act_eff.div == '0) |=> (ref_out != $past(ref_out)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[EN_BIT] && !pri_tick && !sys_tick) |=> $stable(ref_out));

  assert_change_low_R6: assert property (@(posedge clk) disable iff (rst)
    (act_eff != $past(act_eff)) |-> !ref_out);

  assert_sleep_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[EN_BIT] && blocked) |=> $stable(ref_out));
endmodule

bind refclk_gen refclk_gen_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .pri_tick(pri_tick),
  .sys_tick(sys_tick), .pri_mode(pri_mode), .sleep(sleep),
  .ref_out(ref_out), .act_eff(act_eff), .tick_g(tick_g)
);

// File: tb/refclk_gen_test.sv
module refclk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EN = 16'h8000;

  typedef struct packed {
    logic [15:0] word;
    logic [31:0] half;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'h0000, 32'd1},
    '{16'h1100, 32'd2},
    '{16'h0300, 32'd8},
    '{16'h1200, 32'd4},
    '{16'h0500, 32'd32},
    '{16'h1F00, 32'd32768},
    '{16'h3600, 32'd64}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        pri_tick = 1'b0;
  logic        sys_tick = 1'b0;
  logic        pri_mode = 1'b0;
  logic        sleep = 1'b0;
  logic        ref_out;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  refclk_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pri_tick(pri_tick), .sys_tick(sys_tick),
    .pri_mode(pri_mode), .sleep(sleep), .ref_out(ref_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input bit pri);
    @(negedge clk);
    if (pri) pri_tick = 1'b1; else sys_tick = 1'b1;
    @(negedge clk);
    pri_tick = 1'b0; sys_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(ref_out == 1'b0, "R1 ref_out", int'(ref_out), 0);
    chk(cfg_rdata == 16'h0000, "R1 cfg_rdata", int'(cfg_rdata), 0);

    // R2 readback
    wr(16'h4A5C);
    chk(cfg_rdata == 16'h4A5C, "R2 readback", int'(cfg_rdata), 16'h4A5C);

    // Table walk: R4 division, R5 source choice
    for (int v = 0; v < 7; v++) begin
      automatic bit pri = VECS[v].word[12];
      automatic int half = int'(VECS[v].half);
      automatic int n = (half > 64) ? half + 1 : 2 * half + 1;
      automatic int bad = 0;
      automatic int bad_act = 0;
      automatic int bad_exp = 0;
      automatic int other_bad = 0;
      wr(16'h0000);
      wr(VECS[v].word | EN);
      for (int k = 1; k <= n; k++) begin
        automatic logic e = logic'((k / half) % 2);
        tick(pri);
        if (ref_out !== e && bad == 0) begin
          bad = k; bad_act = int'(ref_out); bad_exp = int'(e);
        end
        if (half <= 64) begin
          tick(!pri);
          if (ref_out !== e) other_bad++;
        end
      end
      chk(bad == 0, $sformatf("R4 divide vector %0d", v), bad_act, bad_exp);
      if (half <= 64)
        chk(other_bad == 0, $sformatf("R5 other source vector %0d", v), other_bad, 0);
    end

    // R3 disable clears, re-enable restarts low
    wr(16'h0000);
    wr(EN | 16'h0100);
    tick(1'b0); tick(1'b0); tick(1'b0);
    chk(ref_out == 1'b1, "R3 running high", int'(ref_out), 1);
    wr(16'h0000);
    idle(1);
    chk(ref_out == 1'b0, "R3 disabled low", int'(ref_out), 0);
    wr(EN | 16'h0100);
    tick(1'b0);
    chk(ref_out == 1'b0, "R3 restart first half", int'(ref_out), 0);
    tick(1'b0);
    chk(ref_out == 1'b1, "R3 restart rise", int'(ref_out), 1);

    // R6 change while high waits for low half
    wr(16'h0000);
    wr(EN | 16'h0200);
    for (int k = 0; k < 5; k++) tick(1'b0);
    chk(ref_out == 1'b1, "R6 high before change", int'(ref_out), 1);
    wr(EN | 16'h0000);
    tick(1'b0); tick(1'b0);
    chk(ref_out == 1'b1, "R6 old half kept", int'(ref_out), 1);
    tick(1'b0);
    chk(ref_out == 1'b0, "R6 old half ends", int'(ref_out), 0);
    tick(1'b0);
    chk(ref_out == 1'b1, "R6 new code rise", int'(ref_out), 1);
    tick(1'b0);
    chk(ref_out == 1'b0, "R6 new code fall", int'(ref_out), 0);

    // R7 sleep freeze: system clock source with keep bit
    wr(16'h0000);
    wr(EN | 16'h2000);
    pri_mode = 1'b1;
    tick(1'b0);
    chk(ref_out == 1'b1, "R7 awake toggle", int'(ref_out), 1);
    sleep = 1'b1;
    tick(1'b0); tick(1'b0); tick(1'b0);
    chk(ref_out == 1'b1, "R7 frozen sys source", int'(ref_out), 1);
    sleep = 1'b0;
    tick(1'b0);
    chk(ref_out == 1'b0, "R7 resumes after wake", int'(ref_out), 0);

    // R7 primary source but not in a primary mode
    wr(16'h0000);
    wr(EN | 16'h3000);
    pri_mode = 1'b0;
    sleep = 1'b1;
    tick(1'b1); tick(1'b1);
    chk(ref_out == 1'b0, "R7 frozen no primary mode", int'(ref_out), 0);

    // R8 keeps running in sleep
    pri_mode = 1'b1;
    tick(1'b1);
    chk(ref_out == 1'b1, "R8 sleep run rise", int'(ref_out), 1);
    tick(1'b1);
    chk(ref_out == 1'b0, "R8 sleep run fall", int'(ref_out), 0);
    sleep = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule